// File: doc/BRIEF.md
# Instruction Prefetch Address-Break Unit

This block watches the instruction-prefetch side of a processor core and raises an interrupt request when the core fetches from a programmed word address. Software writes a break address and an enable bit through a two-entry register window. When the core strobes a prefetch to that word while the unit is enabled, a sticky hit flag is set. The flag stays set until software writes zero to it, and it drives the interrupt request line toward a downstream priority controller.

Address bit 0 is never compared, so every break is word-aligned. In narrow (16-bit) addressing mode the upper address byte is left out of the comparison. The request does not pass through the core's own interrupt mask bits. A prefetch that the core later throws away, for example after a taken branch placed just before the break address, still counts as a hit. Software must tell such false hits apart on its own.

Top module: `pfbrk_unit`

## Requirements
- R1: After reset the break-address register (window slot 0) reads 0, the control register (window slot 1) reads 0, and `brk_irq` is 0.
- R2: A write to slot 0 stores bits 23..1 of the write data. Slot 0 always reads back with bit 0 equal to 0.
- R3: When `pf_strobe` is 1 at a clock edge and `pf_addr` equals the break address in bits 23..1, with bit 0 ignored and the unit enabled, the hit flag (control bit 1) is 1 from that edge on.
- R4: A matching `pf_addr` with `pf_strobe` at 0 does not set the hit flag.
- R5: While the enable bit (control bit 0) is 0, no prefetch sets the hit flag.
- R6: With `wide_mode` at 1, bits 23..1 are compared. With `wide_mode` at 0, only bits 15..1 are compared.
- R7: The hit flag stays at 1 until a write to slot 1 with data bit 1 at 0. A write with data bit 1 at 1 leaves the flag unchanged. Data bit 0 of every slot-1 write loads the enable bit.
- R8: If a hit and a clearing write to slot 1 occur at the same edge, the flag ends up 1.
- R9: `brk_irq` is 1 exactly when both the hit flag and the enable bit are 1, so clearing the enable bit withdraws a pending request while the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pf_strobe | input | 1 | Instruction prefetch strobe from the core |
| pf_addr | input | 24 | Prefetch address |
| wide_mode | input | 1 | 1: 24-bit compare, 0: 16-bit compare |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Window slot: 0 break address, 1 control |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Read data of the selected slot |
| brk_irq | output | 1 | Interrupt request to the priority controller |

## Verification
A comparator fault, such as a wrong mask or bit 0 left in the compare, shows up in the control readback one edge after the offending prefetch, as a flag that is set when it should be clear or clear when it should be set. A flag register that loses stickiness or gets the set/clear priority wrong is visible at the first readback after the colliding write. An enable-gating error shows on `brk_irq` in the same cycle as the register state that causes it. The bench therefore reads both slots and the request line after every stimulus step.

// File: rtl/pfbrk_pkg.sv
package pfbrk_pkg;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;

  // equality under a mask of significant bits
  function automatic logic masked_eq(input logic [31:0] a,
                                     input logic [31:0] b,
                                     input logic [31:0] mask);
    return ((a ^ b) & mask) == 32'h0;
  endfunction

  // mask covering bits [width-1:1]
  function automatic logic [31:0] word_mask(input int width);
    return ((32'h1 << width) - 32'h1) & ~32'h1;
  endfunction
endpackage

// File: rtl/pfbrk_cmp.sv
module pfbrk_cmp #(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:1] brk,
  input  logic              wide,
  output logic              raw_hit
);
  import pfbrk_pkg::*;

  localparam logic [31:0] FULL_MASK   = word_mask(ADDR_W);
  localparam logic [31:0] NARROW_MASK = word_mask((NARROW_W < ADDR_W) ? NARROW_W : ADDR_W);

  logic [31:0] addr_x, brk_x, sel_mask;

  always_comb begin
    addr_x   = 32'(addr);
    brk_x    = 32'({brk, 1'b0});
    sel_mask = wide ? FULL_MASK : NARROW_MASK;
    raw_hit  = strobe && masked_eq(addr_x, brk_x, sel_mask);
  end
endmodule

// File: rtl/pfbrk_regs.sv
module pfbrk_regs #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              hit,
  output logic              clr,
  output logic [ADDR_W-1:1] brk_q,
  output logic              en_q,
  output logic              flag_q
);
  import pfbrk_pkg::*;

  logic ctrl_wr;

  always_comb begin
    ctrl_wr = wr && sel;
    clr     = ctrl_wr && !wdata[CTRL_FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr && !sel) brk_q <= wdata[ADDR_W-1:1];
      if (ctrl_wr)    en_q  <= wdata[CTRL_EN_BIT];
      if (hit)        flag_q <= 1'b1;
      else if (clr)   flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pfbrk_unit.sv
module pfbrk_unit #(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_strobe,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              wide_mode,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              brk_irq
);
  import pfbrk_pkg::*;

  logic [ADDR_W-1:1] brk_q;
  logic raw_hit_w, hit_w, clr_w, en_q, flag_q;

  pfbrk_cmp #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_cmp (
    .strobe(pf_strobe), .addr(pf_addr), .brk(brk_q),
    .wide(wide_mode), .raw_hit(raw_hit_w)
  );

  assign hit_w = raw_hit_w && en_q;

  pfbrk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .hit(hit_w), .clr(clr_w),
    .brk_q(brk_q), .en_q(en_q), .flag_q(flag_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[CTRL_EN_BIT]   = en_q;
      reg_rdata[CTRL_FLAG_BIT] = flag_q;
    end else begin
      reg_rdata = {brk_q, 1'b0};
    end
    brk_irq = flag_q && en_q;
  end
endmodule

// File: rtl/pfbrk_chk.sv
module pfbrk_chk (
  input logic clk,
  input logic rst_n,
  input logic hit,
  input logic clr,
  input logic flag,
  input logic en,
  input logic irq
);
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R3
  AST_FLAG_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit)); // R5
  AST_FLAG_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr)); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> flag); // R8
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq); // R9
endmodule

bind pfbrk_unit pfbrk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit_w), .clr(clr_w),
  .flag(flag_q), .en(en_q), .irq(brk_irq)
);

// File: tb/pfbrk_unit_bench.sv
`timescale 1ns/100ps
module pfbrk_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_strobe = 1'b0;
  logic [23:0] pf_addr = '0;
  logic wide_mode = 1'b1;
  logic reg_wr = 1'b0;
  logic reg_sel = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic brk_irq;

  always #2.5 clk = ~clk;

  pfbrk_unit u_pfbrk_unit (
    .clk(clk), .rst_n(rst_n), .pf_strobe(pf_strobe), .pf_addr(pf_addr),
    .wide_mode(wide_mode), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_irq(brk_irq)
  );

  typedef struct {
    string       tag;
    logic        sel;
    logic [23:0] rd;
    logic        irq;
  } item_t;

  item_t exp_q[$];
  item_t cur;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // monitor: compares at the falling edge, inputs change 1 ns later
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      n_checks++;
      if (reg_sel !== cur.sel || reg_rdata !== cur.rd || brk_irq !== cur.irq) begin
        n_errors++;
        $display("FAIL %s: sel=%0b rdata=%h irq=%b expected sel=%0b rdata=%h irq=%b",
                 cur.tag, reg_sel, reg_rdata, brk_irq, cur.sel, cur.rd, cur.irq);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_slot(input string tag, input logic sel,
                             input logic [23:0] rd, input logic irq);
    item_t it;
    pf_strobe = 1'b0;
    reg_wr    = 1'b0;
    reg_sel   = sel;
    it.tag = tag; it.sel = sel; it.rd = rd; it.irq = irq;
    exp_q.push_back(it);
    step();
  endtask

  task automatic write_reg(input logic sel, input logic [23:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic prefetch(input logic [23:0] a);
    pf_strobe = 1'b1; pf_addr = a;
    step();
    pf_strobe = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    expect_slot("R1 reset addr", 1'b0, 24'h0, 1'b0);
    expect_slot("R1 reset ctrl", 1'b1, 24'h0, 1'b0);

    write_reg(1'b0, 24'h123457);
    expect_slot("R2 addr bit0 dropped", 1'b0, 24'h123456, 1'b0);

    write_reg(1'b1, 24'h000001);
    pf_addr = 24'h123456;        // no strobe
    step();
    expect_slot("R4 no strobe no hit", 1'b1, 24'h000001, 1'b0);

    prefetch(24'h123457);        // bit0 differs
    expect_slot("R3 hit sets flag", 1'b1, 24'h000003, 1'b1);

    write_reg(1'b1, 24'h000003);
    expect_slot("R7 write 1 keeps flag", 1'b1, 24'h000003, 1'b1);
    write_reg(1'b1, 24'h000001);
    expect_slot("R7 write 0 clears flag", 1'b1, 24'h000001, 1'b0);

    prefetch(24'h123458);
    expect_slot("R3 other word no hit", 1'b1, 24'h000001, 1'b0);

    wide_mode = 1'b1;
    prefetch(24'hFF3456);
    expect_slot("R6 wide compares upper byte", 1'b1, 24'h000001, 1'b0);
    wide_mode = 1'b0;
    prefetch(24'hFF3456);
    expect_slot("R6 narrow ignores upper byte", 1'b1, 24'h000003, 1'b1);
    wide_mode = 1'b1;
    write_reg(1'b1, 24'h000001);

    write_reg(1'b1, 24'h000000);
    prefetch(24'h123456);
    expect_slot("R5 disabled no hit", 1'b1, 24'h000000, 1'b0);

    write_reg(1'b1, 24'h000001);
    prefetch(24'h123456);
    write_reg(1'b1, 24'h000002);
    expect_slot("R9 disable withdraws irq", 1'b1, 24'h000002, 1'b0);
    write_reg(1'b1, 24'h000003);
    expect_slot("R9 reenable restores irq", 1'b1, 24'h000003, 1'b1);

    write_reg(1'b1, 24'h000001);
    pf_strobe = 1'b1; pf_addr = 24'h123456;
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 24'h000001;
    step();
    pf_strobe = 1'b0; reg_wr = 1'b0;
    expect_slot("R8 set wins over clear", 1'b1, 24'h000003, 1'b1);

    write_reg(1'b1, 24'h000001);
    write_reg(1'b0, 24'h000000);
    prefetch(24'h000001);
    expect_slot("R3 zero address hit", 1'b1, 24'h000003, 1'b1);
    expect_slot("R2 addr zero readback", 1'b0, 24'h000000, 1'b1);

    step();
    done = 1'b1;
    finish_run();
  end
endmodule